// File: doc/BRIEF.md
# Program/Data Space Memory Select Unit

This unit sits behind the address decoder of a microcontroller bus that keeps code and data in separate spaces. A low instruction-fetch strobe (`psen_n`) marks a code access, and a low read strobe (`rd_n`) marks a data read. The decoder reports raw range hits for four targets: SRAM, the I/O window, a secondary boot flash and a main flash. The unit turns those hits into at most one active select, together with one output enable.

A small mapping register sets which strobe may reach each flash, and whether instruction fetches may reach the SRAM. Its value after reset is a parameter, and the CPU can rewrite it while running through a simple write port. Boot code and main flash can therefore trade places between the code space and the data space without a reset.

When more than one permitted target hits, a fixed ladder picks the winner. The SRAM/I/O level is on top, the boot flash is next and the main flash is last. A target that the current strobe may not reach never shadows a target below it.

Top module: `space_select_unit`

## Requirements
- R1: After reset, `cfg_rdata` equals `MAP_RESET` (default 8'h12), and no select or output enable is active while both strobes are high.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_rdata` shows the written value from that edge on, and not before it. The selects follow the new value from that edge on.
- R3: Map bits 7 to 5 always read as zero, whatever value is written to them.
- R4: While `cfg_we` is low, the map value does not change, whatever is driven on `cfg_wdata`.
- R5: An instruction fetch reaches the SRAM only when map bit 0 is set. A data read reaches the SRAM regardless of the map.
- R6: The boot flash is reachable by an instruction fetch when map bit 1 is set, and by a data read when map bit 3 is set.
- R7: The main flash is reachable by an instruction fetch when map bit 2 is set, and by a data read when map bit 4 is set.
- R8: The I/O window answers data reads only. An instruction fetch never selects it.
- R9: At most one select is active at a time. The priority is SRAM, then I/O (both on level one), then the boot flash, then the main flash.
- R10: A hit that is not permitted for the current strobe does not block a lower level. If no permitted hit exists, all selects stay low.
- R11: When both strobes are high, all selects and `mem_oe` are low.
- R12: `mem_oe` is high exactly when one of the selects is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the map register |
| rst_n | input | 1 | Asynchronous active-low reset; loads `MAP_RESET` |
| cfg_we | input | 1 | Map write strobe, sampled at the rising edge |
| cfg_wdata | input | MAP_W | Value to write into the map |
| cfg_rdata | output | MAP_W | Current map value; unused bits read zero |
| psen_n | input | 1 | Instruction-fetch strobe, active low |
| rd_n | input | 1 | Data-read strobe, active low |
| hit_sram | input | 1 | Decoder hit for the SRAM range |
| hit_io | input | 1 | Decoder hit for the I/O window |
| hit_boot | input | 1 | Decoder hit for the boot flash range |
| hit_main | input | 1 | Decoder hit for the main flash range |
| sel_sram | output | 1 | SRAM select, active high |
| sel_io | output | 1 | I/O select, active high |
| sel_boot | output | 1 | Boot flash select, active high |
| sel_main | output | 1 | Main flash select, active high |
| mem_oe | output | 1 | Output enable, high while any target is selected |

## Verification
The checker watches several rules on every clock. It checks that at most one select is active and that every select rests on its own hit and on a permitted strobe. For each select it also checks the map bit that gates it. It checks that unused map bits stay zero, that the map holds without a write and loads one cycle after a write, and that `mem_oe` agrees with the selects. Some behaviour only the bench scenarios can show. That covers the chosen winner when several permitted hits overlap, and a disabled higher level that lets a lower one through. It also covers the reset value and the boot/main swap done by rewriting the map at run time.

// File: rtl/space_sel_pkg.sv
package space_sel_pkg;
   // map bit positions; software relies on these
   localparam int MAP_SRAM_CODE = 0;
   localparam int MAP_BOOT_CODE = 1;
   localparam int MAP_MAIN_CODE = 2;
   localparam int MAP_BOOT_DATA = 3;
   localparam int MAP_MAIN_DATA = 4;
   localparam int MAP_USED      = 5;

   typedef struct packed {
      logic sram;
      logic io;
      logic boot;
      logic main;
   } tgt_vec_t;
endpackage

// File: rtl/space_map_reg.sv
module space_map_reg #(
   parameter int          MAP_W     = 8,
   parameter logic [MAP_W-1:0] MAP_RESET = 8'h12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [MAP_W-1:0] wdata,
   output logic [MAP_W-1:0] q
);
   import space_sel_pkg::*;

   localparam logic [MAP_W-1:0] KEEP_MASK = MAP_W'((1 << MAP_USED) - 1);
   localparam logic [MAP_W-1:0] INIT_VAL  = MAP_RESET & KEEP_MASK;

   logic [MAP_W-1:0] wmasked;
   assign wmasked = wdata & KEEP_MASK;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= INIT_VAL;
      else if (we) q <= wmasked;
   end
endmodule

// File: rtl/space_gate.sv
module space_gate
   import space_sel_pkg::*;
(
   input  logic [MAP_USED-1:0] map,
   input  logic                psen_n,
   input  logic                rd_n,
   input  tgt_vec_t            hit,
   output tgt_vec_t            ok
);
   logic code_acc, data_acc;
   assign code_acc = !psen_n;
   assign data_acc = !rd_n;

   always_comb begin
      ok.sram = hit.sram & (data_acc | (code_acc & map[MAP_SRAM_CODE]));
      ok.io   = hit.io   & data_acc;
      ok.boot = hit.boot & ((code_acc & map[MAP_BOOT_CODE]) |
                            (data_acc & map[MAP_BOOT_DATA]));
      ok.main = hit.main & ((code_acc & map[MAP_MAIN_CODE]) |
                            (data_acc & map[MAP_MAIN_DATA]));
   end
endmodule

// File: rtl/space_prio.sv
module space_prio
   import space_sel_pkg::*;
(
   input  tgt_vec_t ok,
   output tgt_vec_t sel,
   output logic     any
);
   logic lvl1_taken, lvl2_taken;
   assign lvl1_taken = ok.sram | ok.io;
   assign lvl2_taken = lvl1_taken | ok.boot;

   always_comb begin
      sel.sram = ok.sram;
      sel.io   = ok.io   & !ok.sram;
      sel.boot = ok.boot & !lvl1_taken;
      sel.main = ok.main & !lvl2_taken;
   end

   assign any = |sel;
endmodule

// File: rtl/space_select_unit.sv
module space_select_unit #(
   parameter int               MAP_W     = 8,
   parameter logic [MAP_W-1:0] MAP_RESET = 8'h12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [MAP_W-1:0] cfg_wdata,
   output logic [MAP_W-1:0] cfg_rdata,
   input  logic             psen_n,
   input  logic             rd_n,
   input  logic             hit_sram,
   input  logic             hit_io,
   input  logic             hit_boot,
   input  logic             hit_main,
   output logic             sel_sram,
   output logic             sel_io,
   output logic             sel_boot,
   output logic             sel_main,
   output logic             mem_oe
);
   import space_sel_pkg::*;

   if (MAP_W < MAP_USED) begin : g_width_bad
      $error("MAP_W must hold all map bits");
   end
   if ((MAP_RESET >> MAP_USED) != 0) begin : g_reset_bad
      $error("MAP_RESET sets unused map bits");
   end

   tgt_vec_t hit_v, ok_v, sel_v;
   logic     any_v;

   assign hit_v = '{sram: hit_sram, io: hit_io, boot: hit_boot, main: hit_main};

   space_map_reg #(.MAP_W(MAP_W), .MAP_RESET(MAP_RESET)) u_map (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .wdata (cfg_wdata),
      .q     (cfg_rdata)
   );

   space_gate u_gate (
      .map    (cfg_rdata[MAP_USED-1:0]),
      .psen_n (psen_n),
      .rd_n   (rd_n),
      .hit    (hit_v),
      .ok     (ok_v)
   );

   space_prio u_prio (
      .ok  (ok_v),
      .sel (sel_v),
      .any (any_v)
   );

   assign sel_sram = sel_v.sram;
   assign sel_io   = sel_v.io;
   assign sel_boot = sel_v.boot;
   assign sel_main = sel_v.main;
   assign mem_oe   = any_v;
endmodule

// File: rtl/space_select_chk.sv
module space_select_chk #(
   parameter int MAP_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [MAP_W-1:0] cfg_wdata,
   input logic [MAP_W-1:0] cfg_rdata,
   input logic             psen_n,
   input logic             rd_n,
   input logic             hit_sram,
   input logic             hit_io,
   input logic             hit_boot,
   input logic             hit_main,
   input logic             sel_sram,
   input logic             sel_io,
   input logic             sel_boot,
   input logic             sel_main,
   input logic             mem_oe
);
   localparam logic [MAP_W-1:0] KEEP = MAP_W'(8'h1F);

   assert_load_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> cfg_rdata == ($past(cfg_wdata) & KEEP));
   assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_rdata & ~KEEP) == '0);
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we |=> $stable(cfg_rdata));
   assert_sram_fetch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_sram && rd_n) |-> (hit_sram && !psen_n && cfg_rdata[0]));
   assert_boot_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sel_boot |-> (hit_boot && ((!psen_n && cfg_rdata[1]) || (!rd_n && cfg_rdata[3]))));
   assert_main_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sel_main |-> (hit_main && ((!psen_n && cfg_rdata[2]) || (!rd_n && cfg_rdata[4]))));
   assert_io_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sel_io |-> (hit_io && !rd_n));
   assert_single_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sel_sram, sel_io, sel_boot, sel_main}));
   assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (psen_n && rd_n) |-> !(sel_sram || sel_io || sel_boot || sel_main || mem_oe));
   assert_oe_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
      mem_oe == (sel_sram || sel_io || sel_boot || sel_main));
endmodule

bind space_select_unit space_select_chk #(.MAP_W(MAP_W)) u_chk (.*);

// File: tb/space_select_unit_test.sv
module space_select_unit_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic [7:0] cfg_rdata;
   logic       psen_n = 1'b1, rd_n = 1'b1;
   logic       hit_sram = 1'b0, hit_io = 1'b0, hit_boot = 1'b0, hit_main = 1'b0;
   logic       sel_sram, sel_io, sel_boot, sel_main, mem_oe;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   space_select_unit uut (.*);

   // {map, psen_n, rd_n, hits sram/io/boot/main, expected sram/io/boot/main}
   localparam logic [17:0] VEC [0:13] = '{
      {8'h00, 2'b10, 4'b1111, 4'b1000},
      {8'h00, 2'b01, 4'b1000, 4'b0000},
      {8'h01, 2'b01, 4'b1000, 4'b1000},
      {8'h00, 2'b01, 4'b1011, 4'b0000},
      {8'h02, 2'b01, 4'b0011, 4'b0010},
      {8'h04, 2'b01, 4'b0011, 4'b0001},
      {8'h06, 2'b01, 4'b1011, 4'b0010},
      {8'h18, 2'b10, 4'b0011, 4'b0010},
      {8'h10, 2'b10, 4'b0011, 4'b0001},
      {8'h08, 2'b10, 4'b0100, 4'b0100},
      {8'h1F, 2'b01, 4'b0100, 4'b0000},
      {8'h1F, 2'b11, 4'b1111, 4'b0000},
      {8'h00, 2'b10, 4'b1100, 4'b1000},
      {8'h1F, 2'b01, 4'b0101, 4'b0001}
   };

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   endtask

   task automatic check(string req, logic [7:0] act, logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] sels();
      return {3'b0, mem_oe, sel_sram, sel_io, sel_boot, sel_main};
   endfunction

   task automatic write_map(logic [7:0] v);
      @(negedge clk);
      cfg_we = 1'b1;
      cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic drive(logic [1:0] strb, logic [3:0] hits);
      {psen_n, rd_n} = strb;
      {hit_sram, hit_io, hit_boot, hit_main} = hits;
      #2;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         summary();
      end
   end

   initial begin
      #10 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset value and idle outputs
      check("R1 reset map", cfg_rdata, 8'h12);
      drive(2'b11, 4'b1111);
      check("R1/R11 idle after reset", sels(), 8'h00);

      // vector table: R5..R12
      for (int i = 0; i < 14; i++) begin
         logic [3:0] e;
         write_map(VEC[i][17:10]);
         @(negedge clk);
         drive(VEC[i][9:8], VEC[i][7:4]);
         e = VEC[i][3:0];
         check($sformatf("R5-R12 vector %0d (R9 R10 R12)", i), sels(), {3'b0, |e, e});
         drive(2'b11, 4'b0000);
      end

      // R3 unused bits read zero
      write_map(8'hFF);
      check("R3 upper bits", cfg_rdata, 8'h1F);

      // R2 write lands at the edge, not before
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = 8'h0C;
      #2 check("R2 before edge", cfg_rdata, 8'h1F);
      @(negedge clk);
      cfg_we = 1'b0;
      check("R2 after edge", cfg_rdata, 8'h0C);

      // R4 no write, data wiggles
      cfg_wdata = 8'h13;
      @(negedge clk);
      cfg_wdata = 8'h01;
      @(negedge clk);
      check("R4 hold", cfg_rdata, 8'h0C);

      // R6/R7 swap: map 0C = main in code, boot in data
      drive(2'b01, 4'b0011);
      check("R7 swapped fetch to main", sels(), 8'h11);
      drive(2'b10, 4'b0011);
      check("R6 swapped read to boot", sels(), 8'h12);
      drive(2'b11, 4'b0000);
      write_map(8'h12);
      drive(2'b01, 4'b0011);
      check("R6 fetch to boot", sels(), 8'h12);
      drive(2'b10, 4'b0011);
      check("R7 read to main", sels(), 8'h11);
      drive(2'b11, 4'b0000);

      // R8 fetch hitting io with sram fetch disabled: nothing
      drive(2'b01, 4'b0100);
      check("R8 io no fetch", sels(), 8'h00);
      drive(2'b11, 4'b0000);

      // R1 reset mid-run restores map
      write_map(8'h05);
      rst_n = 1'b0;
      #1 check("R1 reset restores", cfg_rdata, 8'h12);
      @(negedge clk);
      rst_n = 1'b1;

      done = 1'b1;
      summary();
   end
endmodule